// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that walks a chain of transfer descriptors held in memory. Software writes the address of the first descriptor and sets the run bit. The channel reads the descriptor over a request/response read port, then copies the described number of bytes one 32-bit word at a time. It reads each word over the same read port and writes it through a separate write port. When a descriptor is finished, the channel follows that descriptor's link word to the next one. A link of zero ends the chain. A descriptor that links back to an earlier one forms an endless ring.

A descriptor occupies 32 bytes. The channel reads the first six words, which are, in order: transfer options, source address, destination address, byte length, stride and link address. The last two words are padding and are never fetched.

Each side of the copy can have its address stepped or held fixed. Each side can also be paced by one of the peripheral request lines. Software can pause the channel, resume it, abandon the current descriptor, or reset the channel. A completion flag and an interrupt flag record finished descriptors. While the channel runs, the live source, destination and length registers let software work out how far a transfer has progressed.

Top module: `ldma_channel`

## Requirements
- R1: After reset, the control/status register (offset 0x00) reads zero, `irq` is low, and neither memory port requests.
- R2: The registers sit at these offsets: control/status 0x00, descriptor address 0x04, options 0x08, source 0x0C, destination 0x10, length 0x14, stride 0x18, link 0x1C, identification 0x20. Every register from 0x04 to 0x1C reads back what was written, except that the length drops its two low bits.
- R3: Writing control/status with bit 0 (run) set while the channel is idle starts a fetch. The channel reads the words at descriptor address +0, +4, +8, +12, +16 and +20, in that order, into options, source, destination, length, stride and link.
- R4: A descriptor with length L performs L/4 read-then-write beats. The length register drops by 4 on each accepted write. The source and destination registers always show the address of the next beat.
- R5: A read request holds its address steady until `mrd_valid` answers it. A write request holds until `mwr_ack` accepts it. Each beat writes the word read from the current source address to the current destination address.
- R6: Control/status bit 1 (done) is set after the last write of a descriptor is accepted. If options bit 3 is set, it waits for a `mwr_resp` pulse first. If options bit 0 is set, bit 2 (interrupt) and `irq` are raised at the same time. Writing 1 to bit 1 or to bit 2 clears that flag.
- R7: A non-zero link makes the channel fetch the linked descriptor and keep run set. A zero link clears run at the end of the descriptor.
- R8: Options bit 8 steps the source by 4 per beat and bit 4 steps the destination by 4 per beat. When the bit is clear, that address stays fixed.
- R9: Options bit 10 paces reads and bit 6 paces writes, using the request line chosen by options bits 20:16. While the chosen line is low, no paced beat starts and status bit 5 (held) is set. Status bit 3 shows the level of the chosen line.
- R10: Writing control/status with bit 0 clear stops the channel before its next bus beat. Status bit 4 (stopped) is set while a chain is in progress and run is clear. Setting bit 0 again resumes with no word lost or repeated.
- R11: Writing bits 30 and 0 together abandons the remaining beats of the current descriptor and moves on to its link. Done and interrupt are not raised for the abandoned descriptor.
- R12: Writing bit 31 returns the channel to idle at once and clears run, done and interrupt.
- R13: With `REDUCED`=1 the length register keeps only bits 15:2, so at most 65532 bytes, and identification bit 28 reads 1. With `REDUCED`=0, lengths keep bits 31:2 and bit 28 reads 0.
- R14: Status bit 6 (write wait) is set while the channel waits for the write response at the end of a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset for reads and writes |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| mrd_req | output | 1 | Memory read request, held until answered |
| mrd_addr | output | 32 | Memory read byte address |
| mrd_valid | input | 1 | Read response strobe |
| mrd_data | input | 32 | Read response data |
| mwr_req | output | 1 | Memory write request, held until accepted |
| mwr_addr | output | 32 | Memory write byte address |
| mwr_data | output | 32 | Memory write data |
| mwr_ack | input | 1 | Write accepted |
| mwr_resp | input | 1 | Write response pulse |
| preq | input | NREQ | Peripheral request lines |
| irq | output | 1 | Interrupt, high while the interrupt flag is set |

## Verification
A register write lands on the clock edge after the strobe, so the bench reads its effect at the next falling edge. The read model answers a request at the falling edge after it sees the request, and the write model accepts in the same way. Every beat therefore costs a fixed handful of cycles, but the bench never counts them. Instead it polls the run bit, or waits until the scoreboard queue is empty, and only then checks the final registers. For pacing and pause it leaves a margin of twenty cycles, which is far longer than any single beat, so the write count it compares is already settled.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int WORD_W = 32;

  localparam logic [5:0] OFS_CTRL   = 6'h00;
  localparam logic [5:0] OFS_BLK    = 6'h04;
  localparam logic [5:0] OFS_OPT    = 6'h08;
  localparam logic [5:0] OFS_SRC    = 6'h0C;
  localparam logic [5:0] OFS_DST    = 6'h10;
  localparam logic [5:0] OFS_LEN    = 6'h14;
  localparam logic [5:0] OFS_STRIDE = 6'h18;
  localparam logic [5:0] OFS_LINK   = 6'h1C;
  localparam logic [5:0] OFS_IDENT  = 6'h20;

  // control/status bit positions
  localparam int CS_RUN     = 0;
  localparam int CS_DONE    = 1;
  localparam int CS_IRQ     = 2;
  localparam int CS_LINE    = 3;
  localparam int CS_STOPPED = 4;
  localparam int CS_HELD    = 5;
  localparam int CS_WRWAIT  = 6;
  localparam int CS_KILL    = 30;
  localparam int CS_CLEAR   = 31;

  // options bit positions
  localparam int OP_IRQEN  = 0;
  localparam int OP_WRESP  = 3;
  localparam int OP_DINC   = 4;
  localparam int OP_DPACE  = 6;
  localparam int OP_SINC   = 8;
  localparam int OP_SPACE  = 10;
  localparam int OP_SEL_LO = 16;

  localparam int ID_REDUCED = 28;
  localparam int CB_WORDS   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_READ, ST_WRITE, ST_RESP, ST_DONE, ST_LINK
  } ch_state_t;
endpackage

// File: rtl/ldma_pace.sv
module ldma_pace import ldma_pkg::*; #(
  parameter int NREQ  = 32,
  parameter int SEL_W = 5
) (
  input  logic [NREQ-1:0]  preq,
  input  logic [SEL_W-1:0] sel,
  input  logic             src_paced,
  input  logic             dst_paced,
  output logic             line,
  output logic             src_hold,
  output logic             dst_hold
);
  assign line     = preq[sel];
  assign src_hold = src_paced & ~line;
  assign dst_hold = dst_paced & ~line;
endmodule

// File: rtl/ldma_csr_view.sv
module ldma_csr_view import ldma_pkg::*; #(
  parameter int REDUCED = 0
) (
  input  logic [5:0]        addr,
  input  logic [WORD_W-1:0] status,
  input  logic [WORD_W-1:0] blk,
  input  logic [WORD_W-1:0] opt,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] len,
  input  logic [WORD_W-1:0] stride,
  input  logic [WORD_W-1:0] link,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] ident;

  always_comb begin
    ident = '0;
    ident[ID_REDUCED] = (REDUCED != 0);
  end

  always_comb begin
    unique case (addr)
      OFS_CTRL:   rdata = status;
      OFS_BLK:    rdata = blk;
      OFS_OPT:    rdata = opt;
      OFS_SRC:    rdata = src;
      OFS_DST:    rdata = dst;
      OFS_LEN:    rdata = len;
      OFS_STRIDE: rdata = stride;
      OFS_LINK:   rdata = link;
      OFS_IDENT:  rdata = ident;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ldma_seq.sv
module ldma_seq import ldma_pkg::*; #(
  parameter logic [WORD_W-1:0] LEN_MASK = 32'hFFFF_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [5:0]        csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic              mrd_req,
  output logic [WORD_W-1:0] mrd_addr,
  input  logic              mrd_valid,
  input  logic [WORD_W-1:0] mrd_data,
  output logic              mwr_req,
  output logic [WORD_W-1:0] mwr_addr,
  output logic [WORD_W-1:0] mwr_data,
  input  logic              mwr_ack,
  input  logic              mwr_resp,
  input  logic              line,
  input  logic              src_hold,
  input  logic              dst_hold,
  output logic [WORD_W-1:0] status,
  output logic [WORD_W-1:0] blk_q,
  output logic [WORD_W-1:0] opt_q,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] dst_q,
  output logic [WORD_W-1:0] len_q,
  output logic [WORD_W-1:0] stride_q,
  output logic [WORD_W-1:0] link_q,
  output logic              irq
);
  localparam logic [WORD_W-1:0] STEP = 32'd4;

  ch_state_t         st_q, st_n;
  logic              run_q, run_n, done_q, done_n, int_q, int_n, kill_q, kill_n;
  logic              rp_q, rp_n, wp_q, wp_n;
  logic [2:0]        fi_q, fi_n;
  logic [WORD_W-1:0] blk_n, opt_n, src_n, dst_n, len_n, stride_n, link_n;
  logic [WORD_W-1:0] beat_q, beat_n;
  logic              held;

  always_comb begin
    st_n = st_q; run_n = run_q; done_n = done_q; int_n = int_q; kill_n = kill_q;
    rp_n = rp_q; wp_n = wp_q; fi_n = fi_q; beat_n = beat_q;
    blk_n = blk_q; opt_n = opt_q; src_n = src_q; dst_n = dst_q;
    len_n = len_q; stride_n = stride_q; link_n = link_q;

    unique case (st_q)
      ST_IDLE: begin
        kill_n = 1'b0;
        if (run_q) begin
          st_n = ST_LOAD;
          fi_n = '0;
        end
      end
      ST_LOAD: begin
        if (rp_q) begin
          if (mrd_valid) begin
            rp_n = 1'b0;
            unique case (fi_q)
              3'd0:    opt_n    = mrd_data;
              3'd1:    src_n    = mrd_data;
              3'd2:    dst_n    = mrd_data;
              3'd3:    len_n    = mrd_data & LEN_MASK;
              3'd4:    stride_n = mrd_data;
              default: link_n   = mrd_data;
            endcase
            if (fi_q == 3'(CB_WORDS - 1)) st_n = ST_READ;
            else                          fi_n = fi_q + 3'd1;
          end
        end else if (kill_q) begin
          st_n = ST_LINK;
        end else if (run_q) begin
          rp_n = 1'b1;
        end
      end
      ST_READ: begin
        if (rp_q) begin
          if (mrd_valid) begin
            rp_n   = 1'b0;
            beat_n = mrd_data;
            st_n   = ST_WRITE;
          end
        end else if (len_q == '0) begin
          st_n = ST_DONE;
        end else if (kill_q) begin
          st_n = ST_LINK;
        end else if (run_q && !src_hold) begin
          rp_n = 1'b1;
        end
      end
      ST_WRITE: begin
        if (wp_q) begin
          if (mwr_ack) begin
            wp_n  = 1'b0;
            len_n = len_q - STEP;
            if (opt_q[OP_SINC]) src_n = src_q + STEP;
            if (opt_q[OP_DINC]) dst_n = dst_q + STEP;
            if (len_q <= STEP) st_n = opt_q[OP_WRESP] ? ST_RESP : ST_DONE;
            else               st_n = ST_READ;
          end
        end else if (kill_q) begin
          st_n = ST_LINK;
        end else if (run_q && !dst_hold) begin
          wp_n = 1'b1;
        end
      end
      ST_RESP: begin
        if (mwr_resp) st_n = ST_DONE;
      end
      ST_DONE: begin
        done_n = 1'b1;
        if (opt_q[OP_IRQEN]) int_n = 1'b1;
        st_n = ST_LINK;
      end
      default: begin
        kill_n = 1'b0;
        if (link_q == '0) begin
          run_n = 1'b0;
          st_n  = ST_IDLE;
        end else begin
          blk_n = link_q;
          fi_n  = '0;
          st_n  = ST_LOAD;
        end
      end
    endcase

    if (csr_wr) begin
      unique case (csr_addr)
        OFS_CTRL: begin
          if (csr_wdata[CS_CLEAR]) begin
            st_n = ST_IDLE; run_n = 1'b0; done_n = 1'b0; int_n = 1'b0;
            kill_n = 1'b0; rp_n = 1'b0; wp_n = 1'b0;
          end else begin
            run_n = csr_wdata[CS_RUN];
            if (csr_wdata[CS_DONE]) done_n = 1'b0;
            if (csr_wdata[CS_IRQ])  int_n  = 1'b0;
            if (csr_wdata[CS_KILL] && csr_wdata[CS_RUN]) kill_n = 1'b1;
          end
        end
        OFS_BLK:    blk_n    = csr_wdata;
        OFS_OPT:    opt_n    = csr_wdata;
        OFS_SRC:    src_n    = csr_wdata;
        OFS_DST:    dst_n    = csr_wdata;
        OFS_LEN:    len_n    = csr_wdata & LEN_MASK;
        OFS_STRIDE: stride_n = csr_wdata;
        OFS_LINK:   link_n   = csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; run_q <= 1'b0; done_q <= 1'b0; int_q <= 1'b0; kill_q <= 1'b0;
      rp_q <= 1'b0; wp_q <= 1'b0; fi_q <= '0; beat_q <= '0;
      blk_q <= '0; opt_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; stride_q <= '0; link_q <= '0;
    end else begin
      st_q <= st_n; run_q <= run_n; done_q <= done_n; int_q <= int_n; kill_q <= kill_n;
      rp_q <= rp_n; wp_q <= wp_n; fi_q <= fi_n; beat_q <= beat_n;
      blk_q <= blk_n; opt_q <= opt_n; src_q <= src_n; dst_q <= dst_n;
      len_q <= len_n; stride_q <= stride_n; link_q <= link_n;
    end
  end

  assign held = run_q && ((st_q == ST_READ && !rp_q && len_q != '0 && src_hold) ||
                          (st_q == ST_WRITE && !wp_q && dst_hold));

  always_comb begin
    status = '0;
    status[CS_RUN]     = run_q;
    status[CS_DONE]    = done_q;
    status[CS_IRQ]     = int_q;
    status[CS_LINE]    = line;
    status[CS_STOPPED] = !run_q && (st_q != ST_IDLE);
    status[CS_HELD]    = held;
    status[CS_WRWAIT]  = (st_q == ST_RESP);
  end

  assign mrd_req  = rp_q;
  assign mrd_addr = (st_q == ST_LOAD) ? (blk_q + {27'd0, fi_q, 2'b00}) : src_q;
  assign mwr_req  = wp_q;
  assign mwr_addr = dst_q;
  assign mwr_data = beat_q;
  assign irq      = int_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !csr_wr) |=> (!mrd_req && !mwr_req)); // R1
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && !mrd_valid && !csr_wr) |=> (mrd_req && $stable(mrd_addr))); // R5
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_req && !mwr_ack && !csr_wr) |=> mwr_req); // R5
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_req && mwr_ack && !csr_wr) |=> (len_q == $past(len_q) - STEP)); // R4
  AST_DST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_req && mwr_ack && !opt_q[OP_DINC] && !csr_wr) |=> $stable(dst_q)); // R8
  AST_PACED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mwr_req) |-> $past(!dst_hold)); // R9
  AST_STOP_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !mrd_req) |=> !mrd_req); // R10
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done_q); // R6
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel import ldma_pkg::*; #(
  parameter int NREQ    = 32,
  parameter int REDUCED = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [5:0]        csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              mrd_req,
  output logic [WORD_W-1:0] mrd_addr,
  input  logic              mrd_valid,
  input  logic [WORD_W-1:0] mrd_data,
  output logic              mwr_req,
  output logic [WORD_W-1:0] mwr_addr,
  output logic [WORD_W-1:0] mwr_data,
  input  logic              mwr_ack,
  input  logic              mwr_resp,
  input  logic [NREQ-1:0]   preq,
  output logic              irq
);
  localparam int SEL_W = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [WORD_W-1:0] LEN_MASK = (REDUCED != 0) ? 32'h0000_FFFC : 32'hFFFF_FFFC;

  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              line, src_hold, dst_hold;
  logic [WORD_W-1:0] status, blk_q, opt_q, src_q, dst_q, len_q, stride_q, link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  ldma_pace #(.NREQ(NREQ), .SEL_W(SEL_W)) pace_i (
    .preq(preq), .sel(opt_q[OP_SEL_LO +: SEL_W]),
    .src_paced(opt_q[OP_SPACE]), .dst_paced(opt_q[OP_DPACE]),
    .line(line), .src_hold(src_hold), .dst_hold(dst_hold)
  );

  ldma_seq #(.LEN_MASK(LEN_MASK)) seq_i (
    .clk(clk), .rst_n(rst_core_n),
    .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_valid(mrd_valid), .mrd_data(mrd_data),
    .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
    .mwr_ack(mwr_ack), .mwr_resp(mwr_resp),
    .line(line), .src_hold(src_hold), .dst_hold(dst_hold),
    .status(status), .blk_q(blk_q), .opt_q(opt_q), .src_q(src_q), .dst_q(dst_q),
    .len_q(len_q), .stride_q(stride_q), .link_q(link_q), .irq(irq)
  );

  ldma_csr_view #(.REDUCED(REDUCED)) view_i (
    .addr(csr_addr), .status(status), .blk(blk_q), .opt(opt_q), .src(src_q),
    .dst(dst_q), .len(len_q), .stride(stride_q), .link(link_q), .rdata(csr_rdata)
  );
endmodule

// File: tb/ldma_channel_tb_top.sv
module ldma_channel_tb_top;
  import ldma_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, csr_wr, lite_wr;
  logic [5:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata, lite_rdata;
  logic        mrd_req, mrd_valid, mwr_req, mwr_ack, mwr_resp, irq;
  logic [31:0] mrd_addr, mrd_data, mwr_addr, mwr_data;
  logic [31:0] preq;
  logic        l_mrd_req, l_mwr_req, l_irq;
  logic [31:0] l_mrd_addr, l_mwr_addr, l_mwr_data;

  ldma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_valid(mrd_valid),
    .mrd_data(mrd_data), .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
    .mwr_ack(mwr_ack), .mwr_resp(mwr_resp), .preq(preq), .irq(irq)
  );

  ldma_channel #(.REDUCED(1)) lite_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(lite_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(lite_rdata), .mrd_req(l_mrd_req), .mrd_addr(l_mrd_addr), .mrd_valid(1'b0),
    .mrd_data(32'd0), .mwr_req(l_mwr_req), .mwr_addr(l_mwr_addr), .mwr_data(l_mwr_data),
    .mwr_ack(1'b0), .mwr_resp(1'b0), .preq(32'd0), .irq(l_irq)
  );

  int checks = 0, errors = 0, wr_seen = 0, resp_cnt = 0;
  bit resp_hold = 0;
  logic [31:0] mem [0:255];
  logic [31:0] exp_a[$], exp_d[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  initial begin
    mrd_valid = 0; mrd_data = 0; mwr_ack = 0; mwr_resp = 0;
    forever begin
      @(negedge clk);
      if (mrd_req && !mrd_valid) begin
        mrd_valid = 1; mrd_data = mem[mrd_addr[9:2]];
      end else mrd_valid = 0;
      mwr_resp = 0;
      if (resp_cnt > 0 && !resp_hold) begin mwr_resp = 1; resp_cnt--; end
      if (mwr_req && !mwr_ack) begin
        mwr_ack = 1; wr_seen++; resp_cnt++;
        mem[mwr_addr[9:2]] = mwr_data;
        if (exp_a.size() == 0) chk("R4 unexpected write", mwr_addr, 32'hFFFF_FFFF);
        else begin
          chk("R5 write address", mwr_addr, exp_a.pop_front());
          chk("R5 write data", mwr_data, exp_d.pop_front());
        end
      end else mwr_ack = 0;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_wr = 1;
    @(negedge clk); csr_wr = 0;
  endtask
  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); csr_addr = a; #1 v = csr_rdata;
  endtask
  task automatic set_cb(input int at, input logic [31:0] op, s, d, n, lk);
    mem[at/4] = op; mem[at/4+1] = s; mem[at/4+2] = d; mem[at/4+3] = n;
    mem[at/4+4] = 0; mem[at/4+5] = lk;
  endtask
  // driver: expected writes derived from the requirements
  task automatic expect_copy(input logic [31:0] s, d, input int n, input bit si, di);
    for (int i = 0; i < n; i++) begin
      exp_a.push_back(di ? d + 4*i : d);
      exp_d.push_back(mem[(si ? s + 4*i : s) >> 2]);
    end
  endtask
  task automatic wait_idle(input string tag);
    logic [31:0] v;
    bit ok = 0;
    for (int k = 0; k < 3000; k++) begin
      rd(OFS_CTRL, v);
      if (!v[CS_RUN]) begin ok = 1; break; end
    end
    chk(tag, {31'd0, ok}, 32'd1);
  endtask
  task automatic start(input logic [31:0] at);
    wr(OFS_BLK, at); wr(OFS_CTRL, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; $display("FAIL watchdog actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0;
    rst_n = 0; csr_wr = 0; lite_wr = 0; csr_addr = 0; csr_wdata = 0; preq = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + i * 32'h0001_0103;
    repeat (4) @(negedge clk); rst_n = 1; repeat (4) @(negedge clk);

    rd(OFS_CTRL, v); chk("R1 status after reset", v, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    chk("R1 no request", {30'd0, mrd_req, mwr_req}, 0);

    wr(OFS_SRC, 32'h1234_5678); rd(OFS_SRC, v); chk("R2 source readback", v, 32'h1234_5678);
    wr(OFS_STRIDE, 32'h0BAD_F00D); rd(OFS_STRIDE, v); chk("R2 stride readback", v, 32'h0BAD_F00D);
    wr(OFS_LINK, 32'h0000_0ABC); rd(OFS_LINK, v); chk("R2 link readback", v, 32'h0000_0ABC);
    wr(OFS_LEN, 32'h0001_0006); rd(OFS_LEN, v); chk("R13 full length kept", v, 32'h0001_0004);
    rd(OFS_IDENT, v); chk("R13 full variant ident", v[ID_REDUCED], 0);

    // single descriptor, both addresses stepped, interrupt enabled
    set_cb(32'h00, 32'h111, 32'h100, 32'h200, 16, 0);
    expect_copy(32'h100, 32'h200, 4, 1, 1);
    start(32'h00); wait_idle("R3 single descriptor finishes");
    chk("R4 all beats written", exp_a.size(), 0);
    rd(OFS_CTRL, v); chk("R6 done and interrupt", v & 32'h7, 32'h6);
    chk("R6 irq raised", {31'd0, irq}, 1);
    rd(OFS_OPT, v); chk("R3 options loaded", v, 32'h111);
    rd(OFS_SRC, v); chk("R4 live source", v, 32'h110);
    rd(OFS_DST, v); chk("R4 live destination", v, 32'h210);
    rd(OFS_LEN, v); chk("R4 length consumed", v, 0);
    wr(OFS_CTRL, 32'h6); rd(OFS_CTRL, v); chk("R6 flags cleared", v, 0);
    chk("R6 irq cleared", {31'd0, irq}, 0);

    // chain of two descriptors
    set_cb(32'h20, 32'h110, 32'h120, 32'h280, 8, 32'h40);
    set_cb(32'h40, 32'h111, 32'h130, 32'h2C0, 12, 0);
    expect_copy(32'h120, 32'h280, 2, 1, 1);
    expect_copy(32'h130, 32'h2C0, 3, 1, 1);
    start(32'h20); wait_idle("R7 chain ends on zero link");
    chk("R7 both descriptors copied", exp_a.size(), 0);
    rd(OFS_CTRL, v); chk("R7 run cleared, flags set", v & 32'h7, 32'h6);
    wr(OFS_CTRL, 32'h6);

    // fixed destination, wait for write response
    set_cb(32'h60, 32'h108, 32'h140, 32'h300, 12, 0);
    expect_copy(32'h140, 32'h300, 3, 1, 0);
    resp_hold = 1; start(32'h60);
    for (int k = 0; k < 500 && exp_a.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    rd(OFS_CTRL, v); chk("R14 write wait shown", v[CS_WRWAIT], 1);
    chk("R6 done waits for response", v[CS_DONE], 0);
    rd(OFS_DST, v); chk("R8 fixed destination", v, 32'h300);
    resp_hold = 0; wait_idle("R6 finishes after response");
    rd(OFS_CTRL, v); chk("R6 done after response", v & 32'h47, 32'h2);
    wr(OFS_CTRL, 32'h6);

    // source paced by line 5
    set_cb(32'h80, 32'h0005_0510, 32'h150, 32'h340, 8, 0);
    expect_copy(32'h150, 32'h340, 2, 1, 1);
    w0 = wr_seen; start(32'h80); repeat (20) @(negedge clk);
    rd(OFS_CTRL, v); chk("R9 held while line low", v & 32'h29, 32'h21);
    chk("R9 no write while held", wr_seen - w0, 0);
    preq[5] = 1; wait_idle("R9 resumes when line high");
    chk("R9 paced copy complete", exp_a.size(), 0);
    preq = 0; wr(OFS_CTRL, 32'h6);

    // pause and resume, destination paced by line 7
    set_cb(32'hA0, 32'h0007_0150, 32'h160, 32'h380, 16, 0);
    expect_copy(32'h160, 32'h380, 4, 1, 1);
    w0 = wr_seen; start(32'hA0); repeat (20) @(negedge clk);
    wr(OFS_CTRL, 32'h0); repeat (2) @(negedge clk);
    rd(OFS_CTRL, v); chk("R10 stopped flag", v & 32'h11, 32'h10);
    preq[7] = 1; repeat (20) @(negedge clk);
    chk("R10 no beat while stopped", wr_seen - w0, 0);
    wr(OFS_CTRL, 32'h1); wait_idle("R10 resumed chain ends");
    chk("R10 no word lost or repeated", wr_seen - w0, 4);
    preq = 0; wr(OFS_CTRL, 32'h6);

    // abandon first descriptor, continue on its link
    set_cb(32'hC0, 32'h0007_0151, 32'h170, 32'h3C0, 8, 32'hE0);
    set_cb(32'hE0, 32'h110, 32'h180, 32'h3E0, 8, 0);
    expect_copy(32'h180, 32'h3E0, 2, 1, 1);
    start(32'hC0); repeat (20) @(negedge clk);
    wr(OFS_CTRL, 32'h4000_0001); wait_idle("R11 chain ends after abandon");
    chk("R11 linked descriptor copied", exp_a.size(), 0);
    rd(OFS_CTRL, v); chk("R11 no interrupt for abandoned", v & 32'h7, 32'h2);
    chk("R11 irq stays low", {31'd0, irq}, 0);
    wr(OFS_CTRL, 32'h6);

    // channel reset mid transfer
    start(32'hC0); repeat (20) @(negedge clk);
    wr(OFS_CTRL, 32'h8000_0000); repeat (2) @(negedge clk);
    rd(OFS_CTRL, v); chk("R12 reset clears status", v & 32'hFFFF_FFF7, 0);
    chk("R12 no request after reset", {30'd0, mrd_req, mwr_req}, 0);

    // reduced variant
    @(negedge clk); csr_addr = OFS_LEN; csr_wdata = 32'h0012_3456; lite_wr = 1;
    @(negedge clk); lite_wr = 0; #1 chk("R13 reduced length masked", lite_rdata, 32'h0000_3454);
    @(negedge clk); csr_addr = OFS_IDENT; #1 chk("R13 reduced ident bit", lite_rdata[ID_REDUCED], 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule